// File: doc/BRIEF.md
# Fast-to-Slow Peripheral Bus Bridge

This block joins a 32-bit processor-side bus to a slower peripheral module bus. On the processor side it is a slave only. It accepts one single-beat read or write at a time and finishes each one with exactly one response pulse: a data acknowledge or an error acknowledge. It never asks the master to retry and never gives up the bus.

The peripheral side covers a 15-bit offset window (32 KB). Inside that window sits a parameter-defined set of module regions. Each region declares whether its bus interface is 32 or 16 bits wide.

- The peripheral side runs at the full processor rate or at half of it, chosen by a configuration input. The bridge drives a clock enable for the peripheral bus.
- Data lanes are steered to suit the target. A 32-bit access to a 16-bit module becomes two halfword transfers, and the processor sees a single acknowledge after both are done.
- Bursts and addresses that hit no region are refused with an error and never reach the peripheral bus.

Top module: `pbus_bridge`

## Requirements
- R1: The default region map, given as offset ranges, is: 0x0000-0x0FFF (32-bit), 0x1000-0x1FFF (16-bit), 0x4000-0x43FF (16-bit) and 0x7000-0x77FF (32-bit). An offset inside a region is forwarded; an offset outside every region is unimplemented.
- R2: An access to an unimplemented offset ends with `rsp_err` and never with `rsp_ack`. Its `rsp_rdata` is zero, no peripheral transfer takes place, and a write to it changes no module contents.
- R3: A request with `req_burst` high ends with `rsp_err` and `rsp_rdata` zero. It makes no peripheral transfer, and a burst write changes no module contents.
- R4: A word access (`req_size`=0) to a 32-bit region makes one transfer. That transfer has `pb_half`=0, `pb_addr` = the offset with bits [1:0] cleared, and all 32 write lanes passed through unchanged. A word read returns `pb_rdata` unchanged.
- R5: A word access to a 16-bit region makes two transfers with `pb_half`=1, in this order:
  - first at the offset with bits [1:0]=00, carrying data bits [31:16] on `pb_wdata[15:0]`;
  - then at the offset with bits [1:0]=10, carrying bits [15:0].
  In both, `pb_wdata[31:16]` is zero. The read result places the first halfword in bits [31:16] and the second in bits [15:0]. The acknowledge comes only after both transfers.
- R6: A halfword access (`req_size`=1) to a 16-bit region makes one transfer at the offset with bit 0 cleared, using processor lane [31:16] when offset bit 1 is 0 and lane [15:0] when it is 1. That lane travels on `pb_wdata[15:0]`, with `pb_wdata[31:16]` zero. A read returns `pb_rdata[15:0]` in the selected lane and zeros in the other lane, whatever the module drives on `pb_rdata[31:16]`.
- R7: A halfword access to a 32-bit region makes one transfer with `pb_half`=1, `pb_addr` = the offset with bit 0 cleared, and `pb_wdata` = `req_wdata` unchanged. A read returns `pb_rdata[31:16]` in bits [31:16] when offset bit 1 is 0, or `pb_rdata[15:0]` in bits [15:0] when it is 1, with the other lane zero.
- R8: With `cfg_half_speed`=0, `pb_ce` is high on every cycle after reset. With `cfg_half_speed`=1, `pb_ce` alternates on every cycle. `pb_sel`, `pb_write`, `pb_half`, `pb_addr` and `pb_wdata` change only at clock edges where `pb_ce` is high. One transfer is one enabled cycle with `pb_sel` high.
- R9: Every accepted request gets exactly one one-cycle response, with `rsp_ack` and `rsp_err` never high together. No response is produced without a request. Write acknowledges carry zero data.
- R10: While `rst_n` is low, `pb_ce`, `pb_sel`, `rsp_ack` and `rsp_err` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor bus clock |
| rst_n | input | 1 | System reset, active low |
| cfg_half_speed | input | 1 | 1 = peripheral side at half rate |
| req_valid | input | 1 | Request present, held until its response |
| req_write | input | 1 | 1 = write, 0 = read |
| req_burst | input | 1 | Request is a burst (refused) |
| req_size | input | 1 | 0 = word, 1 = halfword |
| req_addr | input | 15 | Offset inside the peripheral window |
| req_wdata | input | 32 | Write data, big-endian lanes |
| rsp_ack | output | 1 | Data acknowledge pulse |
| rsp_err | output | 1 | Error acknowledge pulse |
| rsp_rdata | output | 32 | Read data, valid with `rsp_ack` |
| pb_ce | output | 1 | Peripheral bus clock enable |
| pb_sel | output | 1 | Peripheral transfer select |
| pb_write | output | 1 | Peripheral transfer is a write |
| pb_half | output | 1 | Peripheral transfer is a halfword |
| pb_addr | output | 15 | Peripheral transfer offset |
| pb_wdata | output | 32 | Peripheral write data |
| pb_rdata | input | 32 | Peripheral read data, sampled at the enabled edge ending a transfer |

## Verification
Each fault in the bridge's internal state has a distinct signature at the ports:

- **Lost half-transfer flag:** a split access shows up as a missing or repeated halfword on the peripheral bus. The response then either arrives one enabled cycle early or reports a merged word with one stale lane.
- **Wrong decode:** a peripheral transfer appears for an offset that should have been refused, or an error appears where data was due. The next response exposes it.
- **Clock enable out of step:** peripheral outputs change on a disabled cycle. The stability properties catch this within one clock.
- **Stale accumulator:** a halfword read returns nonzero data in the lane it should have cleared.

// File: rtl/pbb_pkg.sv
package pbb_pkg;

  localparam int PBB_AW = 15;
  localparam int PBB_DW = 32;
  localparam int PBB_HW = PBB_DW / 2;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_STROBE,
    ST_RESP
  } pbb_state_e;

  // Offset presented on the peripheral bus for one transfer.
  function automatic logic [PBB_AW-1:0] lane_addr(
    input logic [PBB_AW-1:1] a,
    input logic              is16,
    input logic              half,
    input logic              sel_lo
  );
    if (half)      return {a, 1'b0};
    else if (is16) return {a[PBB_AW-1:2], sel_lo, 1'b0};
    else           return {a[PBB_AW-1:2], 2'b00};
  endfunction

  // Write lanes toward the module: 16-bit targets get one halfword low.
  function automatic logic [PBB_DW-1:0] lane_wdata(
    input logic [PBB_DW-1:0] w,
    input logic              is16,
    input logic              sel_lo
  );
    if (is16) return {{PBB_HW{1'b0}}, (sel_lo ? w[PBB_HW-1:0] : w[PBB_DW-1:PBB_HW])};
    else      return w;
  endfunction

  // Fold one returned peripheral word into the processor-side result.
  function automatic logic [PBB_DW-1:0] lane_rmerge(
    input logic [PBB_DW-1:0] acc,
    input logic [PBB_DW-1:0] rd,
    input logic              is16,
    input logic              half,
    input logic              sel_lo
  );
    logic [PBB_HW-1:0] zh;
    zh = '0;
    if (is16 && !half)
      return sel_lo ? {acc[PBB_DW-1:PBB_HW], rd[PBB_HW-1:0]}
                    : {rd[PBB_HW-1:0], acc[PBB_HW-1:0]};
    else if (is16)
      return sel_lo ? {zh, rd[PBB_HW-1:0]} : {rd[PBB_HW-1:0], zh};
    else if (!half)
      return rd;
    else
      return sel_lo ? {zh, rd[PBB_HW-1:0]} : {rd[PBB_DW-1:PBB_HW], zh};
  endfunction

endpackage

// File: rtl/pbb_ce_gen.sv
module pbb_ce_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic half,
  output logic ce
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ce <= 1'b0;
    else        ce <= half ? ~ce : 1'b1;
  end
endmodule

// File: rtl/pbb_decode.sv
module pbb_decode #(
  parameter int                    NMOD          = 4,
  parameter logic [NMOD*15-1:0]    MOD_BASE      = {15'h7000, 15'h4000, 15'h1000, 15'h0000},
  parameter logic [NMOD*5-1:0]     MOD_SPAN_LOG2 = {5'd11, 5'd10, 5'd12, 5'd12},
  parameter logic [NMOD-1:0]       MOD_IS16      = 4'b0110
) (
  input  logic [pbb_pkg::PBB_AW-1:0] addr,
  output logic                       hit,
  output logic                       is16
);
  localparam int AW = pbb_pkg::PBB_AW;
  localparam int IW = (NMOD > 1) ? $clog2(NMOD) : 1;

  logic [NMOD-1:0] hit_vec;
  logic [IW-1:0]   idx;

  for (genvar gi = 0; gi < NMOD; gi++) begin : g_win
    localparam logic [AW-1:0] BASE = MOD_BASE[gi*AW +: AW];
    localparam int            SPAN = int'(MOD_SPAN_LOG2[gi*5 +: 5]);
    assign hit_vec[gi] = ((addr ^ BASE) >> SPAN) == '0;
  end

  // Lowest region index wins if parameters overlap.
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = NMOD - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        hit = 1'b1;
        idx = IW'(i);
      end
    end
  end

  assign is16 = MOD_IS16[idx];
endmodule

// File: rtl/pbb_lane.sv
module pbb_lane
  import pbb_pkg::*;
(
  input  logic              is16,
  input  logic              half,
  input  logic              wr,
  input  logic [PBB_AW-1:1] a,
  input  logic              part_cur,
  input  logic              part_nx,
  input  logic [PBB_DW-1:0] wdata,
  input  logic [PBB_DW-1:0] rd,
  input  logic [PBB_DW-1:0] acc,
  output logic [PBB_AW-1:0] addr_nx,
  output logic [PBB_DW-1:0] wdata_nx,
  output logic [PBB_DW-1:0] acc_nx,
  output logic              two_part
);
  logic sel_lo_nx, sel_lo_cur;

  assign sel_lo_nx  = half ? a[1] : part_nx;
  assign sel_lo_cur = half ? a[1] : part_cur;
  assign two_part   = is16 && !half;
  assign addr_nx    = lane_addr(a, is16, half, sel_lo_nx);
  assign wdata_nx   = wr ? lane_wdata(wdata, is16, sel_lo_nx) : '0;
  assign acc_nx     = lane_rmerge(acc, rd, is16, half, sel_lo_cur);
endmodule

// File: rtl/pbus_bridge.sv
module pbus_bridge
  import pbb_pkg::*;
#(
  parameter int                 NMOD          = 4,
  parameter logic [NMOD*15-1:0] MOD_BASE      = {15'h7000, 15'h4000, 15'h1000, 15'h0000},
  parameter logic [NMOD*5-1:0]  MOD_SPAN_LOG2 = {5'd11, 5'd10, 5'd12, 5'd12},
  parameter logic [NMOD-1:0]    MOD_IS16      = 4'b0110
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_half_speed,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_burst,
  input  logic              req_size,
  input  logic [PBB_AW-1:0] req_addr,
  input  logic [PBB_DW-1:0] req_wdata,
  output logic              rsp_ack,
  output logic              rsp_err,
  output logic [PBB_DW-1:0] rsp_rdata,
  output logic              pb_ce,
  output logic              pb_sel,
  output logic              pb_write,
  output logic              pb_half,
  output logic [PBB_AW-1:0] pb_addr,
  output logic [PBB_DW-1:0] pb_wdata,
  input  logic [PBB_DW-1:0] pb_rdata
);
  pbb_state_e        state;
  logic              cap_write, cap_half, cap_is16, part, resp_err;
  logic [PBB_AW-1:1] cap_addr;
  logic [PBB_DW-1:0] cap_wdata, acc;

  logic              dec_hit, dec_is16;
  logic [PBB_AW-1:0] ln_addr;
  logic [PBB_DW-1:0] ln_wdata, ln_acc;
  logic              ln_two;
  logic              part_nx;

  // Named internal events for the checker.
  logic ev_accept, ev_reject, ev_close;

  pbb_ce_gen u_ce (
    .clk   (clk),
    .rst_n (rst_n),
    .half  (cfg_half_speed),
    .ce    (pb_ce)
  );

  pbb_decode #(
    .NMOD          (NMOD),
    .MOD_BASE      (MOD_BASE),
    .MOD_SPAN_LOG2 (MOD_SPAN_LOG2),
    .MOD_IS16      (MOD_IS16)
  ) u_dec (
    .addr (req_addr),
    .hit  (dec_hit),
    .is16 (dec_is16)
  );

  assign part_nx = (state == ST_STROBE);

  pbb_lane u_lane (
    .is16     (cap_is16),
    .half     (cap_half),
    .wr       (cap_write),
    .a        (cap_addr),
    .part_cur (part),
    .part_nx  (part_nx),
    .wdata    (cap_wdata),
    .rd       (pb_rdata),
    .acc      (acc),
    .addr_nx  (ln_addr),
    .wdata_nx (ln_wdata),
    .acc_nx   (ln_acc),
    .two_part (ln_two)
  );

  assign ev_accept = (state == ST_IDLE) && req_valid && !req_burst && dec_hit;
  assign ev_reject = (state == ST_IDLE) && req_valid && (req_burst || !dec_hit);
  assign ev_close  = (state == ST_STROBE) && pb_ce;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cap_write <= 1'b0;
      cap_half  <= 1'b0;
      cap_is16  <= 1'b0;
      cap_addr  <= '0;
      cap_wdata <= '0;
      part      <= 1'b0;
      resp_err  <= 1'b0;
      acc       <= '0;
      pb_sel    <= 1'b0;
      pb_write  <= 1'b0;
      pb_half   <= 1'b0;
      pb_addr   <= '0;
      pb_wdata  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            cap_write <= req_write;
            cap_half  <= req_size;
            cap_is16  <= dec_is16;
            cap_addr  <= req_addr[PBB_AW-1:1];
            cap_wdata <= req_wdata;
            part      <= 1'b0;
            acc       <= '0;
            resp_err  <= ev_reject;
            state     <= ev_reject ? ST_RESP : ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (pb_ce) begin
            pb_sel   <= 1'b1;
            pb_write <= cap_write;
            pb_half  <= cap_half || cap_is16;
            pb_addr  <= ln_addr;
            pb_wdata <= ln_wdata;
            state    <= ST_STROBE;
          end
        end
        ST_STROBE: begin
          if (pb_ce) begin
            acc <= ln_acc;
            if (ln_two && !part) begin
              part     <= 1'b1;
              pb_addr  <= ln_addr;
              pb_wdata <= ln_wdata;
            end else begin
              pb_sel   <= 1'b0;
              pb_write <= 1'b0;
              state    <= ST_RESP;
            end
          end
        end
        ST_RESP: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign rsp_ack   = (state == ST_RESP) && !resp_err;
  assign rsp_err   = (state == ST_RESP) && resp_err;
  assign rsp_rdata = (rsp_ack && !cap_write) ? acc : '0;
endmodule

// File: rtl/pbb_checker.sv
module pbb_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_half_speed,
  input logic        pb_ce,
  input logic        pb_sel,
  input logic        pb_write,
  input logic        pb_half,
  input logic [14:0] pb_addr,
  input logic [31:0] pb_wdata,
  input logic        rsp_ack,
  input logic        rsp_err,
  input logic [31:0] rsp_rdata,
  input logic        ev_accept,
  input logic        ev_reject
);
  p_pb_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !pb_ce |=> ($stable(pb_sel) && $stable(pb_write) && $stable(pb_half)
                && $stable(pb_addr) && $stable(pb_wdata)));

  p_full_ce_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_half_speed |=> pb_ce);

  p_half_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_half_speed && pb_ce) |=> !pb_ce);

  p_half_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_half_speed && !pb_ce) |=> pb_ce);

  p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_ack && rsp_err));

  p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_ack || rsp_err) |=> !(rsp_ack || rsp_err));

  p_accept_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> !(rsp_ack || rsp_err));

  p_err_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_rdata == '0));

  p_reject_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_reject |=> (rsp_err && !pb_sel));

  p_resp_idle_bus_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_ack || rsp_err) |-> !pb_sel);
endmodule

bind pbus_bridge pbb_checker u_chk (.*);

// File: tb/pbus_bridge_bench.sv
module pbus_bridge_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_half_speed = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_burst = 1'b0, req_size = 1'b0;
  logic [14:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_ack, rsp_err, pb_ce, pb_sel, pb_write, pb_half;
  logic [31:0] rsp_rdata, pb_wdata;
  logic [14:0] pb_addr;
  logic [31:0] pb_rdata = '0;

  always #10 clk = ~clk;

  pbus_bridge u_pbus_bridge (.*);

  typedef struct packed { logic err; logic [31:0] data; logic [3:0] rq; } rsp_t;
  typedef struct packed { logic wr; logic half; logic [14:0] addr; logic [31:0] wd; logic [3:0] rq; } pbx_t;

  rsp_t        rsp_q[$];
  pbx_t        pbx_q[$];
  logic [15:0] sh [int];
  logic [15:0] pm [int];
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic check(bit ok, int rq, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL R%0d %s act=%h exp=%h", rq, what, act, exp);
    end
  endtask

  // Region map per R1: -1 = unimplemented, else region index.
  function automatic int region(logic [14:0] a);
    if (a < 15'h1000) return 0;
    if (a < 15'h2000) return 1;
    if (a >= 15'h4000 && a < 15'h4400) return 2;
    if (a >= 15'h7000 && a < 15'h7800) return 3;
    return -1;
  endfunction
  function automatic bit narrow(logic [14:0] a);
    int r = region(a);
    return (r == 1) || (r == 2);
  endfunction
  function automatic logic [15:0] shget(int k);
    return sh.exists(k) ? sh[k] : 16'h0;
  endfunction
  function automatic logic [15:0] pmget(int k);
    return pm.exists(k) ? pm[k] : 16'h0;
  endfunction

  // Driver: computes expectations, then runs one request.
  task automatic do_req(bit wr, bit burst, bit half, logic [14:0] a, logic [31:0] w, int rq);
    rsp_t r;
    logic [14:0] aw, ah;
    logic [31:0] exp;
    aw = {a[14:2], 2'b00};
    ah = {a[14:1], 1'b0};
    exp = '0;
    if (burst || region(a) < 0) begin
      r = '{err: 1'b1, data: 32'h0, rq: 4'(rq)};  // R2 / R3
    end else begin
      if (!half) begin
        if (narrow(a)) begin  // R5: upper half first
          pbx_q.push_back('{wr, 1'b1, aw, wr ? {16'h0, w[31:16]} : 32'h0, 4'(rq)});
          pbx_q.push_back('{wr, 1'b1, aw + 15'd2, wr ? {16'h0, w[15:0]} : 32'h0, 4'(rq)});
        end else begin        // R4
          pbx_q.push_back('{wr, 1'b0, aw, wr ? w : 32'h0, 4'(rq)});
        end
        if (wr) begin sh[int'(aw)] = w[31:16]; sh[int'(aw) + 2] = w[15:0]; end
        else exp = {shget(int'(aw)), shget(int'(aw) + 2)};
      end else begin          // R6 / R7
        if (narrow(a))
          pbx_q.push_back('{wr, 1'b1, ah, wr ? {16'h0, (a[1] ? w[15:0] : w[31:16])} : 32'h0, 4'(rq)});
        else
          pbx_q.push_back('{wr, 1'b1, ah, wr ? w : 32'h0, 4'(rq)});
        if (wr) sh[int'(ah)] = a[1] ? w[15:0] : w[31:16];
        else exp = a[1] ? {16'h0, shget(int'(ah))} : {shget(int'(ah)), 16'h0};
      end
      r = '{err: 1'b0, data: exp, rq: 4'(rq)};
    end
    rsp_q.push_back(r);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_burst = burst; req_size = half;
    req_addr = a; req_wdata = w;
    do @(negedge clk); while (!(rsp_ack || rsp_err));
    req_valid = 1'b0; req_burst = 1'b0;
    @(negedge clk);
  endtask

  // Response monitor (R9 and data checks).
  always @(negedge clk) begin
    if (rst_n && (rsp_ack || rsp_err)) begin
      if (rsp_q.size() == 0) begin
        check(0, 9, "response without request", 64'(rsp_ack), 64'h0);
      end else begin
        rsp_t e;
        e = rsp_q.pop_front();
        check(rsp_err == e.err, int'(e.rq), "error flag", 64'(rsp_err), 64'(e.err));
        check(rsp_rdata == e.data, int'(e.rq), "read data", 64'(rsp_rdata), 64'(e.data));
      end
    end
  end

  // Peripheral model and transfer monitor (R4-R8).
  always @(negedge clk) begin
    if (rst_n && pb_sel) begin
      logic [14:0] al;
      al = {pb_addr[14:2], 2'b00};
      if (narrow(pb_addr)) pb_rdata = {16'hA5A5, pmget(int'(pb_addr))};
      else                 pb_rdata = {pmget(int'(al)), pmget(int'(al) + 2)};
      if (pb_ce) begin
        if (pbx_q.size() == 0) begin
          check(0, 2, "unexpected peripheral transfer", 64'(pb_addr), 64'h0);
        end else begin
          pbx_t e;
          logic [48:0] got, want;
          e = pbx_q.pop_front();
          got  = {pb_write, pb_half, pb_addr, pb_write ? pb_wdata : 32'h0};
          want = {e.wr, e.half, e.addr, e.wd};
          check(got == want, int'(e.rq), "peripheral transfer", 64'(got), 64'(want));
        end
        if (pb_write) begin
          if (!pb_half) begin
            pm[int'(pb_addr)] = pb_wdata[31:16];
            pm[int'(pb_addr) + 2] = pb_wdata[15:0];
          end else if (narrow(pb_addr)) begin
            pm[int'(pb_addr)] = pb_wdata[15:0];
          end else begin
            pm[int'(pb_addr)] = pb_addr[1] ? pb_wdata[15:0] : pb_wdata[31:16];
          end
        end
      end
    end
  end

  task automatic ce_pattern(bit half);
    int ones = 0;
    bit bad_alt = 0;
    logic prev;
    @(negedge clk);
    prev = pb_ce;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (pb_ce) ones++;
      if (half && pb_ce == prev) bad_alt = 1;
      prev = pb_ce;
    end
    check(ones == (half ? 6 : 12), 8, "enable count", 64'(ones), 64'(half ? 6 : 12));
    check(!bad_alt, 8, "enable alternation", 64'(bad_alt), 64'h0);
  endtask

  task automatic suite(logic [14:0] o);
    do_req(1, 0, 0, 15'h0010 + o, 32'h1234_5678, 4);  // R4
    do_req(0, 0, 0, 15'h0010 + o, 0, 4);
    do_req(1, 0, 0, 15'h1008 + o, 32'hCAFE_0BEE, 5);  // R5
    do_req(0, 0, 0, 15'h1008 + o, 0, 5);
    do_req(0, 0, 1, 15'h1008 + o, 0, 6);              // R6
    do_req(0, 0, 1, 15'h100A + o, 0, 6);
    do_req(1, 0, 1, 15'h100A + o, 32'h0000_7777, 6);
    do_req(0, 0, 0, 15'h1008 + o, 0, 5);
    do_req(1, 0, 1, 15'h7006 + o, 32'h0000_9999, 7);  // R7
    do_req(1, 0, 1, 15'h7004 + o, 32'h8888_0000, 7);
    do_req(0, 0, 0, 15'h7004 + o, 0, 7);
    do_req(0, 0, 1, 15'h7004 + o, 0, 7);
    do_req(0, 0, 1, 15'h7006 + o, 0, 7);
    do_req(1, 0, 0, 15'h2000 + o, 32'hFFFF_FFFF, 2);  // R2
    do_req(0, 0, 0, 15'h2004 + o, 0, 2);
    do_req(1, 1, 0, 15'h0010 + o, 32'hDEAD_BEEF, 3);  // R3
    do_req(0, 1, 0, 15'h0010 + o, 0, 3);
    do_req(0, 0, 0, 15'h0010 + o, 0, 3);
    do_req(1, 0, 1, 15'h43FE, 32'h0000_4321, 1);      // R1 edges
    do_req(0, 0, 1, 15'h43FE, 0, 1);
    do_req(0, 0, 1, 15'h4400, 0, 1);
    do_req(0, 0, 0, 15'h0FFC, 0, 1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check({pb_ce, pb_sel, rsp_ack, rsp_err} == 4'b0, 10, "reset outputs",
          64'({pb_ce, pb_sel, rsp_ack, rsp_err}), 64'h0);
    rst_n = 1'b1;
    for (int m = 0; m < 2; m++) begin
      cfg_half_speed = m[0];
      repeat (2) @(negedge clk);
      ce_pattern(m[0]);
      suite(m[0] ? 15'h0020 : 15'h0000);
    end
    repeat (4) @(negedge clk);
    check(rsp_q.size() == 0, 9, "responses outstanding", 64'(rsp_q.size()), 64'h0);
    check(pbx_q.size() == 0, 5, "transfers outstanding", 64'(pbx_q.size()), 64'h0);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(0, 9, "watchdog expired", 64'h1, 64'h0);
    finish_run();
  end
endmodule